// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns 32-bit linear addresses into 32-bit physical addresses for a processor core. A request carries a linear address; the reply carries either a physical address or a fault indication. A small fully associative translation cache answers repeated accesses to a page without touching memory. On a miss, a hardware walker reads two tables from memory. It reads a directory entry first and then, when that entry points to a table, a second-level entry.

A directory entry can map a 4 MB region directly. It can also point to a table of 1024 entries, each of which maps a 4 KB page. Both kinds of mapping live side by side in the same cache. A base register, loaded through a write strobe, gives the frame that holds the directory. A flush input empties the cache in one cycle. Only one walk is in flight at a time. Further requests wait while it runs.

Linear address layout: bits [31:22] index the directory, bits [21:12] index the table, and bits [11:0] are the byte offset. A 4 MB mapping uses bits [21:0] as the offset. Entry layout: bit 0 is the present flag. Bit 7 of a directory entry selects a 4 MB mapping. Bits [31:12] give the table or page frame, and bits [31:22] give the frame of a 4 MB mapping.

Top module: `pgxlate_top`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0, memReqValid is 0, and the cache holds no valid entry.
- R2: A request that hits the cache is answered in the cycle after it is accepted, with rspFault 0 and no memory read. The reply keeps the request's offset bits.
- R3: On a miss, the first memory read goes to {base[19:0], va[31:22], 2'b00}. When the directory entry has bit 0 set and bit 7 clear, the second read goes to {entry[31:12], va[21:12], 2'b00}. The reply is then {tableEntry[31:12], va[11:0]}.
- R4: A present directory entry with bit 7 set ends the walk after one read, with reply {entry[31:22], va[21:0]}. Bit 7 of a second-level entry has no effect.
- R5: An entry with bit 0 clear, at either level, gives a reply with rspFault 1 and rspAddr 0, and nothing is stored in the cache. Repeating the same address walks again.
- R6: A successful walk stores its mapping. Later requests anywhere in the same 4 KB page, or the same 4 MB region for a large mapping, hit. Both kinds stay cached at the same time.
- R7: A fill goes to the lowest-numbered invalid entry. When all 32 entries are valid, it goes to the entry named by a round-robin pointer. That pointer starts at 0 and advances, wrapping, only on such fills.
- R8: During a walk, reqReady is 0 from the lookup cycle until the reply cycle, inclusive. The reply comes in the cycle after the last memory response is taken.
- R9: Asserting flush invalidates every entry at that clock edge. A fill at the same edge is dropped, and the round-robin pointer keeps its value.
- R10: A memory request holds memReqValid and memAddr steady until memReqReady is seen, and its address is word aligned.
- R11: A cycle with baseWe high loads baseIn into the base register. Later directory reads use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all cache entries |
| baseWe | input | 1 | Load the directory base register |
| baseIn | input | 20 | New directory frame number |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Request accepted at this edge when both are high |
| reqAddr | input | 32 | Linear address |
| rspValid | output | 1 | Reply present for one cycle |
| rspFault | output | 1 | Reply is a not-present fault |
| rspAddr | output | 32 | Physical address, 0 on a fault |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the read |
| memAddr | output | 32 | Byte address of the 32-bit entry |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 32 | Entry read from memory |

## Verification
The hardest condition to reach from the ports is round-robin replacement. It only starts once all 32 entries are valid. The bench therefore flushes and then walks 36 different small pages, so fills come from the pointer. It then revisits early pages, whose hit or miss is decided by the eviction order. A second hard corner is a flush arriving at the same edge as the final table response. The bench raises flush together with that response and then checks that the same address walks again.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int LOFF_W = OFF_W + IDX_W;
  localparam int PRES_BIT  = 0;
  localparam int LARGE_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_DREQ, ST_DWAIT, ST_TREQ, ST_TWAIT, ST_RESP
  } xlState_e;

  typedef struct packed {
    logic loadVa;
    logic loadPde;
    logic selTable;
    logic fillEn;
    logic fillLarge;
    logic loadRsp;
    logic rspFaultSet;
    logic outWalk;
  } xlStrobe_t;
endpackage

// File: rtl/xl_ctrl.sv
module xl_ctrl
  import xl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hit,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      entPresent,
  input  logic      entLarge,
  output logic      reqReady,
  output logic      rspValid,
  output logic      memReqValid,
  output xlStrobe_t stb
);
  xlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    stb         = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.loadVa = 1'b1;
          stateD     = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hit) begin
          rspValid = 1'b1;
          reqReady = 1'b1;
          if (reqValid) stb.loadVa = 1'b1;
          else          stateD     = ST_IDLE;
        end else begin
          stateD = ST_DREQ;
        end
      end
      ST_DREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_DWAIT;
      end
      ST_DWAIT: begin
        if (memRspValid) begin
          if (!entPresent) begin
            stb.loadRsp     = 1'b1;
            stb.rspFaultSet = 1'b1;
            stateD          = ST_RESP;
          end else if (entLarge) begin
            stb.loadRsp   = 1'b1;
            stb.fillEn    = 1'b1;
            stb.fillLarge = 1'b1;
            stateD        = ST_RESP;
          end else begin
            stb.loadPde = 1'b1;
            stateD      = ST_TREQ;
          end
        end
      end
      ST_TREQ: begin
        memReqValid  = 1'b1;
        stb.selTable = 1'b1;
        if (memReqReady) stateD = ST_TWAIT;
      end
      ST_TWAIT: begin
        stb.selTable = 1'b1;
        if (memRspValid) begin
          stb.loadRsp = 1'b1;
          if (!entPresent) stb.rspFaultSet = 1'b1;
          else             stb.fillEn      = 1'b1;
          stateD = ST_RESP;
        end
      end
      ST_RESP: begin
        rspValid    = 1'b1;
        stb.outWalk = 1'b1;
        stateD      = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/xl_dpath.sv
module xl_dpath
  import xl_pkg::*;
#(
  parameter  int ENTRIES = 32,
  localparam int PTR_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             baseWe,
  input  logic [VPN_W-1:0] baseIn,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic [VA_W-1:0]  memRspData,
  input  xlStrobe_t        stb,
  output logic             hit,
  output logic [VA_W-1:0]  rspAddr,
  output logic             rspFault,
  output logic [VA_W-1:0]  memAddr
);
  logic [VA_W-1:0]    vaQ, walkPaQ;
  logic [VPN_W-1:0]   baseQ, pdeFrameQ;
  logic               walkFaultQ;
  logic [ENTRIES-1:0] vldQ, lrgQ, match;
  logic [VPN_W-1:0]   tagQ [ENTRIES];
  logic [VPN_W-1:0]   pfnQ [ENTRIES];
  logic [PTR_W-1:0]   ptrQ, hitIdx, freeIdx, fillIdx;
  logic               anyFree;
  logic [VA_W-1:0]    hitPa;

  // Tag compare: a large entry ignores the table index bits.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vldQ[i]
      && (tagQ[i][VPN_W-1:IDX_W] == vaQ[VA_W-1:LOFF_W])
      && (lrgQ[i] || (tagQ[i][IDX_W-1:0] == vaQ[LOFF_W-1:OFF_W]));
  end

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hitIdx  = PTR_W'(i);
      if (!vldQ[i]) freeIdx = PTR_W'(i);
    end
  end

  assign hit     = |match;
  assign anyFree = ~&vldQ;
  assign fillIdx = anyFree ? freeIdx : ptrQ;
  assign hitPa   = lrgQ[hitIdx]
                 ? {pfnQ[hitIdx][VPN_W-1:IDX_W], vaQ[LOFF_W-1:0]}
                 : {pfnQ[hitIdx], vaQ[OFF_W-1:0]};

  assign memAddr  = stb.selTable
                  ? {pdeFrameQ, vaQ[LOFF_W-1:OFF_W], 2'b00}
                  : {baseQ, vaQ[VA_W-1:LOFF_W], 2'b00};
  assign rspAddr  = stb.outWalk ? walkPaQ : hitPa;
  assign rspFault = stb.outWalk & walkFaultQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ        <= '0;
      baseQ      <= '0;
      pdeFrameQ  <= '0;
      walkPaQ    <= '0;
      walkFaultQ <= 1'b0;
    end else begin
      if (stb.loadVa)  vaQ       <= reqAddr;
      if (baseWe)      baseQ     <= baseIn;
      if (stb.loadPde) pdeFrameQ <= memRspData[VA_W-1:OFF_W];
      if (stb.loadRsp) begin
        walkFaultQ <= stb.rspFaultSet;
        if (stb.rspFaultSet)
          walkPaQ <= '0;
        else if (stb.fillLarge)
          walkPaQ <= {memRspData[VA_W-1:LOFF_W], vaQ[LOFF_W-1:0]};
        else
          walkPaQ <= {memRspData[VA_W-1:OFF_W], vaQ[OFF_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ <= '0;
      ptrQ <= '0;
    end else if (flush) begin
      vldQ <= '0;
    end else if (stb.fillEn) begin
      vldQ[fillIdx] <= 1'b1;
      if (!anyFree)
        ptrQ <= (ptrQ == PTR_W'(ENTRIES - 1)) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fillEn && !flush) begin
      tagQ[fillIdx] <= vaQ[VA_W-1:OFF_W];
      pfnQ[fillIdx] <= memRspData[VA_W-1:OFF_W];
      lrgQ[fillIdx] <= stb.fillLarge;
    end
  end
endmodule

// File: rtl/pgxlate_top.sv
module pgxlate_top
  import xl_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        baseWe,
  input  logic [19:0] baseIn,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  output logic        rspValid,
  output logic        rspFault,
  output logic [31:0] rspAddr,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);
  xlStrobe_t stb;
  logic      hit;

  xl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .hit        (hit),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .entPresent (memRspData[PRES_BIT]),
    .entLarge   (memRspData[LARGE_BIT]),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .memReqValid(memReqValid),
    .stb        (stb)
  );

  xl_dpath #(.ENTRIES(ENTRIES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .baseWe    (baseWe),
    .baseIn    (baseIn),
    .reqAddr   (reqAddr),
    .memRspData(memRspData),
    .stb       (stb),
    .hit       (hit),
    .rspAddr   (rspAddr),
    .rspFault  (rspFault),
    .memAddr   (memAddr)
  );
endmodule

// File: rtl/xl_chk.sv
module xl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqAddr,
  input logic        rspValid,
  input logic        rspFault,
  input logic [31:0] rspAddr,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memAddr
);
  logic [31:0] lastAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    lastAddr <= '0;
    else if (reqValid && reqReady) lastAddr <= reqAddr;
  end

  // R2: the lookup cycle after acceptance never issues a memory read
  a_r2_lookup_first: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !memReqValid);

  // R2: a good reply keeps the request's page offset
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspAddr[11:0] == lastAddr[11:0]);

  // R5: fault replies carry a zero address
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspAddr == 32'h0);

  // R8: no new request and no reply while a memory read is pending
  a_r8_walk_blocks: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady && !rspValid);

  // R10: request held steady until taken
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr));

  // R10: word aligned entry address
  a_r10_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memAddr[1:0] == 2'b00);
endmodule

bind pgxlate_top xl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqAddr    (reqAddr),
  .rspValid   (rspValid),
  .rspFault   (rspFault),
  .rspAddr    (rspAddr),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memAddr    (memAddr)
);

// File: tb/sim_pgxlate_top.sv
module sim_pgxlate_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        baseWe = 1'b0;
  logic [19:0] baseIn = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        rspValid, rspFault;
  logic [31:0] rspAddr;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int nCmp = 0;
  int nBad = 0;

  // Behavioural model state
  logic [19:0] curBase = 20'h00010;
  bit          mV [32];
  bit          mL [32];
  logic [19:0] mTag [32];
  logic [19:0] mPfn [32];
  int          mPtr = 0;

  always #2 clk = ~clk;

  pgxlate_top u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pdeOf(input logic [9:0] d);
    case (d[1:0])
      2'd3:    return 32'h0000_0F7E;
      2'd2:    return {d ^ 10'h155, 14'b0, 8'h81};
      default: return {20'h40000 + {10'b0, d}, 12'h061};
    endcase
  endfunction

  function automatic logic [31:0] pteOf(input logic [9:0] d, input logic [9:0] t);
    logic [19:0] f;
    if (t[2:0] == 3'd5) return 32'h0000_0FFE;
    f = ({10'b0, d} * 20'd977 + {10'b0, t} * 20'd131) ^ 20'h5A5A5;
    return {f, 12'h081};
  endfunction

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [19:0] tb;
    if (a[31:12] == curBase) return pdeOf(a[11:2]);
    tb = a[31:12] - 20'h40000;
    return pteOf(tb[9:0], a[11:2]);
  endfunction

  function automatic int mLook(input logic [31:0] va);
    for (int i = 0; i < 32; i++)
      if (mV[i] && mTag[i][19:10] == va[31:22] && (mL[i] || mTag[i][9:0] == va[21:12]))
        return i;
    return -1;
  endfunction

  task automatic mFill(input logic [31:0] va, input logic [19:0] pfn, input bit lg);
    int idx = -1;
    for (int i = 31; i >= 0; i--) if (!mV[i]) idx = i;
    if (idx < 0) begin
      idx = mPtr;
      mPtr = (mPtr + 1) % 32;
    end
    mV[idx] = 1; mL[idx] = lg; mTag[idx] = va[31:12]; mPfn[idx] = pfn;
  endtask

  task automatic mFlush();
    for (int i = 0; i < 32; i++) mV[i] = 0;
  endtask

  // One memory read: current time is a negedge in the request cycle.
  task automatic memRead(input string tag, input logic [31:0] exp, input int stall,
                         input int lat, input bit flushWithRsp);
    for (int s = 0; s < stall; s++) begin
      chk({tag, " R10 held valid"}, {31'b0, memReqValid}, 32'h1);
      chk({tag, " R10 held addr"}, memAddr, exp);
      memReqReady = 1'b0;
      @(negedge clk);
    end
    chk({tag, " R3 read valid"}, {31'b0, memReqValid}, 32'h1);
    chk({tag, " R3 read addr"}, memAddr, exp);
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    for (int l = 0; l < lat; l++) begin
      chk({tag, " R8 wait no reply"}, {31'b0, rspValid}, 32'h0);
      @(negedge clk);
    end
    memRspValid = 1'b1;
    memRspData  = memWord(exp);
    if (flushWithRsp) flush = 1'b1;
    @(negedge clk);
    memRspValid = 1'b0;
    memRspData  = 32'hDEAD_BEEF;
    flush       = 1'b0;
  endtask

  task automatic xlate(input string tag, input logic [31:0] va, input int stall,
                       input int lat, input bit flushWithRsp);
    int          h;
    logic [31:0] p, q, expPa;
    bit          flt, lg;
    h = mLook(va);
    @(negedge clk);
    chk({tag, " R8 ready before"}, {31'b0, reqReady}, 32'h1);
    reqValid = 1'b1;
    reqAddr  = va;
    @(negedge clk);
    reqValid = 1'b0;
    if (h >= 0) begin
      expPa = mL[h] ? {mPfn[h][19:10], va[21:0]} : {mPfn[h], va[11:0]};
      chk({tag, " R2 hit valid"}, {31'b0, rspValid}, 32'h1);
      chk({tag, " R2 hit fault"}, {31'b0, rspFault}, 32'h0);
      chk({tag, " R6 hit addr"}, rspAddr, expPa);
      chk({tag, " R2 no read"}, {31'b0, memReqValid}, 32'h0);
      @(negedge clk);
      chk({tag, " R2 one reply"}, {31'b0, rspValid}, 32'h0);
      chk({tag, " R2 still no read"}, {31'b0, memReqValid}, 32'h0);
      return;
    end
    chk({tag, " R8 lookup no reply"}, {31'b0, rspValid}, 32'h0);
    chk({tag, " R8 lookup not ready"}, {31'b0, reqReady}, 32'h0);
    chk({tag, " R2 lookup no read"}, {31'b0, memReqValid}, 32'h0);
    @(negedge clk);
    p  = pdeOf(va[31:22]);
    lg = 0;
    if (!p[0]) begin
      memRead({tag, " dir"}, {curBase, va[31:22], 2'b00}, stall, lat, flushWithRsp);
      flt = 1; expPa = 32'h0;
    end else if (p[7]) begin
      memRead({tag, " dir"}, {curBase, va[31:22], 2'b00}, stall, lat, flushWithRsp);
      flt = 0; lg = 1; expPa = {p[31:22], va[21:0]};
    end else begin
      memRead({tag, " dir"}, {curBase, va[31:22], 2'b00}, stall, lat, 1'b0);
      q = pteOf(va[31:22], va[21:12]);
      memRead({tag, " tbl"}, {p[31:12], va[21:12], 2'b00}, stall, lat, flushWithRsp);
      flt = !q[0];
      expPa = flt ? 32'h0 : {q[31:12], va[11:0]};
    end
    chk({tag, " R8 walk reply"}, {31'b0, rspValid}, 32'h1);
    chk({tag, " R5 fault flag"}, {31'b0, rspFault}, {31'b0, flt});
    chk({tag, " R4 walk addr"}, rspAddr, expPa);
    chk({tag, " R8 reply not ready"}, {31'b0, reqReady}, 32'h0);
    if (flushWithRsp) mFlush();
    else if (!flt) mFill(va, lg ? p[31:12] : q[31:12], lg);
    @(negedge clk);
    chk({tag, " R8 reply done"}, {31'b0, rspValid}, 32'h0);
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    mFlush();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) mV[i] = 0;
    baseIn = 20'h00010;
    baseWe = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    baseWe = 1'b0;
    // R1 reset state
    chk("R1 reqReady", {31'b0, reqReady}, 32'h1);
    chk("R1 rspValid", {31'b0, rspValid}, 32'h0);
    chk("R1 memReqValid", {31'b0, memReqValid}, 32'h0);

    // R3 small walk, then R2/R6 hit
    xlate("R3 small miss", {10'd0, 10'd3, 12'h123}, 0, 0, 0);
    xlate("R2 small hit", {10'd0, 10'd3, 12'hABC}, 0, 0, 0);
    xlate("R3 small miss2", {10'd1, 10'd9, 12'h004}, 2, 3, 0);
    // R4 large mapping, then hits elsewhere in the region
    xlate("R4 large miss", {10'd2, 22'h12345}, 1, 1, 0);
    xlate("R4 large hit", {10'd2, 22'h3FFFFF}, 0, 0, 0);
    xlate("R6 small still hit", {10'd0, 10'd3, 12'h000}, 0, 0, 0);
    // R5 faults at both levels, no fill
    xlate("R5 dir fault", {10'd3, 10'd1, 12'h010}, 0, 2, 0);
    xlate("R5 dir fault again", {10'd3, 10'd1, 12'h010}, 0, 0, 0);
    xlate("R5 tbl fault", {10'd4, 10'd5, 12'h777}, 3, 0, 0);
    xlate("R5 tbl fault again", {10'd4, 10'd5, 12'h777}, 0, 0, 0);
    // R9 flush
    doFlush();
    xlate("R9 miss after flush", {10'd0, 10'd3, 12'h456}, 0, 0, 0);
    xlate("R9 flush with fill", {10'd5, 10'd6, 12'h321}, 0, 1, 1);
    xlate("R9 dropped fill", {10'd5, 10'd6, 12'h321}, 0, 0, 0);
    xlate("R9 large after", {10'd6, 22'h000FF}, 0, 0, 0);
    xlate("R9 large hit", {10'd6, 22'h2000F}, 0, 0, 0);
    // R7 fill order and round-robin replacement
    doFlush();
    for (int i = 0; i < 36; i++)
      xlate("R7 fill", {10'(i % 2), 10'(i * 8 + 1), 12'(i * 4)}, i % 3, i % 2, 0);
    for (int i = 0; i < 8; i++)
      xlate("R7 revisit", {10'(i % 2), 10'(i * 8 + 1), 12'h008}, 0, 0, 0);
    for (int i = 30; i < 36; i++)
      xlate("R7 recent", {10'(i % 2), 10'(i * 8 + 1), 12'h00C}, 0, 0, 0);
    // R11 new directory base
    @(negedge clk);
    baseIn = 20'h00021;
    baseWe = 1'b1;
    @(negedge clk);
    baseWe  = 1'b0;
    curBase = 20'h00021;
    xlate("R11 new base", {10'd9, 10'd17, 12'hF00}, 0, 0, 0);
    xlate("R11 new base large", {10'd10, 22'h1}, 1, 0, 0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule